// File: doc/BRIEF.md
# Serial Flash Power-Up and Access Sequencer

This block sits on the host side, between the logic that requests flash commands and a serial NOR flash device. It holds every access back until the device's supply and reset timing rules are met. It then lets one command at a time through to a downstream serial shifter by driving chip select low. While the shifter runs, the block does no serial shifting and decodes no opcodes. All time limits are given in nanoseconds and turned into system clock cycles from a clock-frequency parameter, always rounded up.

After power-good rises, reads are allowed once a short supply-settling window has passed. Program and erase requests wait for a much longer window. Until then they are stalled with a not-ready handshake, and they are not dropped. Consecutive commands are separated by a minimum chip-select high time. A device reset is a timed low pulse followed by a recovery interval. After a write-class command, the block ignores ready/busy for a short masking window. It then polls ready/busy until the device reports ready, and it raises a sticky error if a programmable cycle limit runs out first. Losing power-good returns the block to its initial state at once.

Top module: `flash_pu_seq`

## Requirements
- R1: After system reset with power-good low: chip select high, device reset output high, request-ready low, command-active low, busy error low.
- R2: Request-ready stays low until power-good has been high for READ_CYC consecutive clock edges, where READ_CYC = ceil(READ_WAIT_NS × CLK_HZ / 1e9). It is high from the cycle after that edge for a read request (reqWrite = 0).
- R3: A write-class request (reqWrite = 1) sees request-ready low until power-good has been high for WRITE_CYC edges. The request is held pending, not dropped, and it is accepted once the window ends.
- R4: A request is accepted on a clock edge where reqValid and reqReady are both high. Chip select goes low and command-active goes high from the next cycle. Both hold until cmdDone is sampled high, and chip select is high in the cycle after that.
- R5: Between two commands, request-ready stays low until chip select has been high for DESEL_CYC edges. Chip select therefore stays high at least that long between commands.
- R6: rstReq sampled high in the idle state takes priority over a request in the same cycle, which sees request-ready low. The device reset output is then low for exactly RST_CYC cycles. Request-ready stays low for a further REC_CYC cycles after the reset output is released.
- R7: After a write-class command ends, ready/busy is not examined for MASK_CYC cycles. Polling then begins, and request-ready stays low until ready/busy is sampled high (high = ready).
- R8: If ready/busy is sampled low on busyLimit consecutive polling edges, busyErr is set and the block returns to idle. busyErr stays set across later commands until a device reset is started or power-good falls.
- R9: Power-good low returns the block to its initial state on the next cycle: chip select high, command-active low, all timing windows restarted.
- R10: Every cycle count is the nanosecond value times CLK_HZ divided by 1e9, rounded up. For example, 50 ns at 125 MHz gives 7 cycles and 100 ns gives 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| pwrGood | input | 1 | Supply has reached its minimum operating voltage |
| reqValid | input | 1 | Requester has a command waiting |
| reqWrite | input | 1 | Waiting command is program or erase (1) or read (0) |
| reqReady | output | 1 | Command may be accepted this cycle |
| cmdActive | output | 1 | Shifter owns the device; command in progress |
| cmdDone | input | 1 | Shifter pulse: command bits finished |
| rstReq | input | 1 | Request a timed device reset pulse |
| flashCsN | output | 1 | Active-low chip select to the flash |
| flashRstN | output | 1 | Active-low reset to the flash |
| rdyBusy | input | 1 | Device ready/busy, high = ready |
| busyLimit | input | BUSY_W | Maximum low polling samples before error |
| busyErr | output | 1 | Sticky busy-timeout error |

## Verification
The bench builds the block at 125 MHz with windows shortened to 400 ns for reads, 2000 ns for writes, 200 ns for the reset pulse and 80 ns for recovery. This gives 50, 250, 25 and 10 cycles, so both power-up thresholds, the reset pulse and the recovery are reached in a few hundred cycles. The 50 ns and 100 ns defaults for deselect and masking are kept, because they round up to 7 and 13 cycles. Those values exercise the rounding rule directly. A busy limit of 20 makes the timeout path reachable, and holding ready/busy high through the masking window shows that it is not sampled there.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [2:0] {
    ST_OFF, ST_IDLE, ST_ACTIVE, ST_MASK, ST_POLL, ST_RSTLOW, ST_RECOV
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic csLow;     // chip select currently low
    logic clrPhase;  // restart phase timer (state change)
    logic pollRun;   // ready/busy polling in progress
    logic errSet;    // timeout reached
    logic errClr;    // device reset starting
  } seqStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic readOk;
    logic writeOk;
    logic deselOk;
    logic pulseDone;
    logic recovDone;
    logic maskDone;
    logic timeoutHit;
  } seqStatus_t;

  // round-up conversion of a time in ns to clock cycles
  function automatic longint unsigned nsToCycles(longint unsigned ns, longint unsigned hz);
    return (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
  endfunction

endpackage

// File: rtl/fps_datapath.sv
module fps_datapath
  import fps_pkg::*;
#(
  parameter int READ_CYC  = 5000,
  parameter int WRITE_CYC = 2000000,
  parameter int DESEL_CYC = 5,
  parameter int RST_CYC   = 1000,
  parameter int REC_CYC   = 100,
  parameter int MASK_CYC  = 10,
  parameter int BUSY_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrGood,
  input  logic              rdyBusy,
  input  logic [BUSY_W-1:0] busyLimit,
  input  seqStrobe_t        strb,
  output seqStatus_t        stat,
  output logic              busyErr
);

  localparam int UP_W   = $clog2(WRITE_CYC + 1);
  localparam int DS_W   = $clog2(DESEL_CYC + 1);
  localparam int PH_MAX = (RST_CYC > REC_CYC) ? ((RST_CYC > MASK_CYC) ? RST_CYC : MASK_CYC)
                                              : ((REC_CYC > MASK_CYC) ? REC_CYC : MASK_CYC);
  localparam int PH_W   = $clog2(PH_MAX + 1);

  localparam logic [UP_W-1:0] UP_TOP     = UP_W'(WRITE_CYC);
  localparam logic [UP_W-1:0] READ_MARK  = UP_W'(READ_CYC);
  localparam logic [DS_W-1:0] DS_TOP     = DS_W'(DESEL_CYC);
  localparam logic [PH_W-1:0] PH_TOP     = PH_W'(PH_MAX);
  localparam logic [PH_W-1:0] PULSE_LAST = PH_W'(RST_CYC - 1);
  localparam logic [PH_W-1:0] REC_LAST   = PH_W'(REC_CYC - 1);
  localparam logic [PH_W-1:0] MASK_LAST  = PH_W'(MASK_CYC - 1);

  logic [UP_W-1:0]   upCnt;
  logic [DS_W-1:0]   deselCnt;
  logic [PH_W-1:0]   phCnt;
  logic [BUSY_W-1:0] busyCnt;

  // edges since power-good rose, saturating at the write window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                upCnt <= '0;
    else if (!pwrGood)        upCnt <= '0;
    else if (upCnt != UP_TOP) upCnt <= upCnt + UP_W'(1);
  end

  // edges since chip select rose; starts satisfied
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    deselCnt <= DS_TOP;
    else if (!pwrGood)            deselCnt <= DS_TOP;
    else if (strb.csLow)          deselCnt <= '0;
    else if (deselCnt != DS_TOP)  deselCnt <= deselCnt + DS_W'(1);
  end

  // shared phase timer: reset pulse, recovery, busy mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        phCnt <= '0;
    else if (!pwrGood || strb.clrPhase) phCnt <= '0;
    else if (phCnt != PH_TOP)         phCnt <= phCnt + PH_W'(1);
  end

  // consecutive busy samples while polling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              busyCnt <= '0;
    else if (!strb.pollRun) busyCnt <= '0;
    else if (!rdyBusy)      busyCnt <= busyCnt + BUSY_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      busyErr <= 1'b0;
    else if (!pwrGood || strb.errClr) busyErr <= 1'b0;
    else if (strb.errSet)           busyErr <= 1'b1;
  end

  always_comb begin
    stat.readOk     = upCnt >= READ_MARK;
    stat.writeOk    = upCnt == UP_TOP;
    stat.deselOk    = deselCnt == DS_TOP;
    stat.pulseDone  = phCnt == PULSE_LAST;
    stat.recovDone  = phCnt == REC_LAST;
    stat.maskDone   = phCnt == MASK_LAST;
    stat.timeoutHit = strb.pollRun && !rdyBusy &&
                      (({1'b0, busyCnt} + (BUSY_W+1)'(1)) >= {1'b0, busyLimit});
  end

  // R2: chip select never falls before the read window
  assert_read_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.csLow) |-> (upCnt >= READ_MARK));

  // R5: chip select falls only after the deselect gap
  assert_desel_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.csLow) |-> (deselCnt == DS_TOP));

  // R8: the error appears only after a busy sample while polling
  assert_err_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyErr) |-> $past(strb.pollRun && !rdyBusy));

  // R9: power loss clears the windows and the error
  assert_off_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> (upCnt == '0 && !busyErr));

endmodule

// File: rtl/fps_control.sv
module fps_control
  import fps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrGood,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       cmdDone,
  input  logic       rstReq,
  input  logic       rdyBusy,
  input  seqStatus_t stat,
  output seqStrobe_t strb,
  output logic       reqReady,
  output logic       cmdActive,
  output logic       flashCsN,
  output logic       flashRstN
);

  seqState_t state, nxt;
  logic      curWrite;
  logic      accept;

  assign reqReady = (state == ST_IDLE) && !rstReq && stat.readOk && stat.deselOk &&
                    (!reqWrite || stat.writeOk);
  assign accept   = reqValid && reqReady;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OFF:    nxt = ST_IDLE;
      ST_IDLE:   if (rstReq) nxt = ST_RSTLOW;
                 else if (accept) nxt = ST_ACTIVE;
      ST_ACTIVE: if (cmdDone) nxt = curWrite ? ST_MASK : ST_IDLE;
      ST_MASK:   if (stat.maskDone) nxt = ST_POLL;
      ST_POLL:   if (rdyBusy || stat.timeoutHit) nxt = ST_IDLE;
      ST_RSTLOW: if (stat.pulseDone) nxt = ST_RECOV;
      ST_RECOV:  if (stat.recovDone) nxt = ST_IDLE;
      default:   nxt = ST_OFF;
    endcase
    if (!pwrGood) nxt = ST_OFF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OFF;
      curWrite <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && accept && !rstReq) curWrite <= reqWrite;
    end
  end

  always_comb begin
    strb.csLow    = (state == ST_ACTIVE);
    strb.clrPhase = (nxt != state);
    strb.pollRun  = (state == ST_POLL);
    strb.errSet   = (state == ST_POLL) && !rdyBusy && stat.timeoutHit;
    strb.errClr   = (state == ST_IDLE) && (nxt == ST_RSTLOW);
  end

  assign cmdActive = (state == ST_ACTIVE);
  assign flashCsN  = !(state == ST_ACTIVE);
  assign flashRstN = !(state == ST_RSTLOW);

  // R3: a write command starts only after the write window
  assert_write_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cmdActive) && curWrite) |-> stat.writeOk);

  // R4: every chip-select fall follows an accepted request
  assert_fresh_select_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flashCsN) |-> $past(reqValid && reqReady));

  // R6: the reset pulse starts only on request
  assert_rst_on_request_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flashRstN) |-> $past(rstReq));

  // R7: the mask window never completes the command directly
  assert_mask_no_finish_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MASK) |=> (state != ST_IDLE));

  // R9: power loss forces the device pins inactive
  assert_off_pins_R9: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> (flashCsN && flashRstN && !cmdActive));

endmodule

// File: rtl/flash_pu_seq.sv
module flash_pu_seq
  import fps_pkg::*;
#(
  parameter longint unsigned CLK_HZ        = 100_000_000,
  parameter longint unsigned READ_WAIT_NS  = 50_000,
  parameter longint unsigned WRITE_WAIT_NS = 20_000_000,
  parameter longint unsigned DESEL_NS      = 50,
  parameter longint unsigned RST_PULSE_NS  = 10_000,
  parameter longint unsigned RST_RECOV_NS  = 1_000,
  parameter longint unsigned BUSY_MASK_NS  = 100,
  parameter int              BUSY_W        = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrGood,
  input  logic              reqValid,
  input  logic              reqWrite,
  output logic              reqReady,
  output logic              cmdActive,
  input  logic              cmdDone,
  input  logic              rstReq,
  output logic              flashCsN,
  output logic              flashRstN,
  input  logic              rdyBusy,
  input  logic [BUSY_W-1:0] busyLimit,
  output logic              busyErr
);

  localparam int READ_CYC  = int'(nsToCycles(READ_WAIT_NS,  CLK_HZ));
  localparam int WRITE_CYC = int'(nsToCycles(WRITE_WAIT_NS, CLK_HZ));
  localparam int DESEL_CYC = int'(nsToCycles(DESEL_NS,      CLK_HZ));
  localparam int RST_CYC   = int'(nsToCycles(RST_PULSE_NS,  CLK_HZ));
  localparam int REC_CYC   = int'(nsToCycles(RST_RECOV_NS,  CLK_HZ));
  localparam int MASK_CYC  = int'(nsToCycles(BUSY_MASK_NS,  CLK_HZ));

  seqStrobe_t strb;
  seqStatus_t stat;

  fps_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .pwrGood   (pwrGood),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .cmdDone   (cmdDone),
    .rstReq    (rstReq),
    .rdyBusy   (rdyBusy),
    .stat      (stat),
    .strb      (strb),
    .reqReady  (reqReady),
    .cmdActive (cmdActive),
    .flashCsN  (flashCsN),
    .flashRstN (flashRstN)
  );

  fps_datapath #(
    .READ_CYC  (READ_CYC),
    .WRITE_CYC (WRITE_CYC),
    .DESEL_CYC (DESEL_CYC),
    .RST_CYC   (RST_CYC),
    .REC_CYC   (REC_CYC),
    .MASK_CYC  (MASK_CYC),
    .BUSY_W    (BUSY_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .pwrGood   (pwrGood),
    .rdyBusy   (rdyBusy),
    .busyLimit (busyLimit),
    .strb      (strb),
    .stat      (stat),
    .busyErr   (busyErr)
  );

endmodule

// File: tb/flash_pu_seq_tb.sv
`timescale 1ns/1ps
module flash_pu_seq_tb;

  // cycle counts expected from the requirements at 125 MHz
  localparam int EXP_READ  = 50;   // 400 ns
  localparam int EXP_WRITE = 250;  // 2000 ns
  localparam int EXP_DESEL = 7;    // 50 ns rounded up (R10)
  localparam int EXP_RST   = 25;   // 200 ns
  localparam int EXP_REC   = 10;   // 80 ns
  localparam int EXP_MASK  = 13;   // 100 ns rounded up (R10)
  localparam int LIMIT     = 20;

  localparam int SIG_READY = 0, SIG_CS = 1, SIG_RST = 2, SIG_ERR = 3, SIG_ACT = 4;

  logic clk = 0, rstN = 0, pwrGood = 0, reqValid = 0, reqWrite = 0;
  logic cmdDone = 0, rstReq = 0, rdyBusy = 1;
  logic [31:0] busyLimit = LIMIT;
  logic reqReady, cmdActive, flashCsN, flashRstN, busyErr;

  int cyc = 0;
  int compared = 0, mismatched = 0;
  bit done = 0;

  int    qCyc[$];
  int    qSig[$];
  logic  qVal[$];
  string qTag[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_pu_seq #(
    .CLK_HZ(125_000_000), .READ_WAIT_NS(400), .WRITE_WAIT_NS(2000),
    .DESEL_NS(50), .RST_PULSE_NS(200), .RST_RECOV_NS(80), .BUSY_MASK_NS(100),
    .BUSY_W(32)
  ) u_dut (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .cmdActive(cmdActive), .cmdDone(cmdDone), .rstReq(rstReq),
    .flashCsN(flashCsN), .flashRstN(flashRstN), .rdyBusy(rdyBusy),
    .busyLimit(busyLimit), .busyErr(busyErr)
  );

  function automatic logic pick(int sig);
    case (sig)
      SIG_READY: return reqReady;
      SIG_CS:    return flashCsN;
      SIG_RST:   return flashRstN;
      SIG_ERR:   return busyErr;
      default:   return cmdActive;
    endcase
  endfunction

  // driver side: queue an expected output value for an absolute cycle
  task automatic expectAt(int at, int sig, logic val, string tag);
    qCyc.push_back(at); qSig.push_back(sig); qVal.push_back(val); qTag.push_back(tag);
  endtask

  task automatic waitTo(int at);
    while (cyc < at) @(negedge clk);
  endtask

  // monitor: compare queued items when their cycle comes up
  always @(negedge clk) begin
    #1;
    for (int i = qCyc.size() - 1; i >= 0; i--) begin
      if (qCyc[i] == cyc) begin
        logic act;
        act = pick(qSig[i]);
        compared++;
        if (act !== qVal[i]) begin
          mismatched++;
          $display("FAIL %s cycle %0d: actual %0b expected %0b", qTag[i], cyc, act, qVal[i]);
        end
        qCyc.delete(i); qSig.delete(i); qVal.delete(i); qTag.delete(i);
      end
    end
  end

  initial begin
    int c0, a, d, e, d2, f, d3, d4, g, r, h, c1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: initial outputs
    expectAt(cyc, SIG_CS,    1'b1, "R1 csN");
    expectAt(cyc, SIG_RST,   1'b1, "R1 rstN");
    expectAt(cyc, SIG_READY, 1'b0, "R1 ready");
    expectAt(cyc, SIG_ACT,   1'b0, "R1 active");
    expectAt(cyc, SIG_ERR,   1'b0, "R1 err");
    @(negedge clk);

    // R2: read window
    pwrGood = 1; c0 = cyc;
    expectAt(c0 + EXP_READ - 1, SIG_READY, 1'b0, "R2 before read window");
    expectAt(c0 + EXP_READ,     SIG_READY, 1'b1, "R2 at read window");

    // R3: write request stalled, then accepted
    waitTo(c0 + EXP_READ + 2);
    reqValid = 1; reqWrite = 1;
    expectAt(cyc, SIG_READY, 1'b0, "R3 write stalled");
    expectAt(c0 + EXP_WRITE - 1, SIG_READY, 1'b0, "R3 before write window");
    expectAt(c0 + EXP_WRITE,     SIG_READY, 1'b1, "R3 at write window");
    expectAt(c0 + EXP_WRITE,     SIG_CS,    1'b1, "R4 csN before accept");
    expectAt(c0 + EXP_WRITE + 1, SIG_CS,    1'b0, "R3 R4 held write accepted");
    expectAt(c0 + EXP_WRITE + 1, SIG_ACT,   1'b1, "R4 active");
    waitTo(c0 + EXP_WRITE + 1);
    reqValid = 0; reqWrite = 0;

    // R7: mask then poll with rdyBusy already high
    a = c0 + EXP_WRITE + 3; d = a + 1;
    waitTo(a); cmdDone = 1;
    expectAt(a, SIG_CS, 1'b0, "R4 csN held until done");
    expectAt(d, SIG_CS, 1'b1, "R4 csN high after done");
    expectAt(d + EXP_MASK,     SIG_READY, 1'b0, "R7 R10 busy ignored in mask");
    expectAt(d + EXP_MASK + 1, SIG_READY, 1'b1, "R7 poll completes");
    waitTo(d); cmdDone = 0;

    // R8: busy timeout
    e = d + EXP_MASK + 3;
    waitTo(e); reqValid = 1; reqWrite = 1;
    waitTo(e + 1); reqValid = 0; reqWrite = 0;
    waitTo(e + 3); cmdDone = 1;
    d2 = e + 4;
    waitTo(d2); cmdDone = 0; rdyBusy = 0;
    expectAt(d2 + EXP_MASK + LIMIT - 1, SIG_ERR,   1'b0, "R8 err before limit");
    expectAt(d2 + EXP_MASK + LIMIT - 1, SIG_READY, 1'b0, "R8 still polling");
    expectAt(d2 + EXP_MASK + LIMIT,     SIG_ERR,   1'b1, "R8 err at limit");
    expectAt(d2 + EXP_MASK + LIMIT,     SIG_READY, 1'b1, "R8 back to idle");
    waitTo(d2 + EXP_MASK + LIMIT); rdyBusy = 1;

    // R5: back-to-back reads and deselect gap
    f = d2 + EXP_MASK + LIMIT + 2;
    waitTo(f); reqValid = 1; reqWrite = 0;
    waitTo(f + 2); cmdDone = 1;
    d3 = f + 3;
    waitTo(d3); cmdDone = 0;
    expectAt(d3 + EXP_DESEL - 1, SIG_READY, 1'b0, "R5 R10 gap not yet met");
    expectAt(d3 + EXP_DESEL,     SIG_READY, 1'b1, "R5 gap met");
    expectAt(d3 + EXP_DESEL,     SIG_CS,    1'b1, "R5 csN still high");
    expectAt(d3 + EXP_DESEL + 1, SIG_CS,    1'b0, "R5 next command");
    waitTo(d3 + EXP_DESEL + 1); reqValid = 0;
    waitTo(d3 + EXP_DESEL + 2); cmdDone = 1;
    d4 = d3 + EXP_DESEL + 3;
    waitTo(d4); cmdDone = 0;
    expectAt(d4, SIG_ERR, 1'b1, "R8 err sticky");

    // R6: reset pulse and recovery with a competing request
    g = d4 + EXP_DESEL + 2;
    waitTo(g); rstReq = 1; reqValid = 1; reqWrite = 0;
    expectAt(g, SIG_READY, 1'b0, "R6 reset has priority");
    r = g + 1;
    expectAt(r, SIG_RST, 1'b0, "R6 pulse start");
    expectAt(r, SIG_ERR, 1'b0, "R8 err cleared by reset");
    expectAt(r, SIG_CS,  1'b1, "R6 csN high in reset");
    expectAt(r + EXP_RST - 1, SIG_RST, 1'b0, "R6 pulse end");
    expectAt(r + EXP_RST,     SIG_RST, 1'b1, "R6 pulse released");
    expectAt(r + EXP_RST + EXP_REC - 1, SIG_READY, 1'b0, "R6 recovery");
    expectAt(r + EXP_RST + EXP_REC,     SIG_READY, 1'b1, "R6 recovery done");
    expectAt(r + EXP_RST + EXP_REC + 1, SIG_CS,    1'b0, "R6 request after recovery");
    waitTo(r); rstReq = 0;
    waitTo(r + EXP_RST + EXP_REC + 1); reqValid = 0;

    // R9: power loss during a command
    h = r + EXP_RST + EXP_REC + 3;
    waitTo(h); pwrGood = 0;
    expectAt(h + 1, SIG_CS,    1'b1, "R9 csN high on power loss");
    expectAt(h + 1, SIG_ACT,   1'b0, "R9 command dropped");
    expectAt(h + 1, SIG_READY, 1'b0, "R9 not ready");
    waitTo(h + 1); pwrGood = 1; reqValid = 1; c1 = cyc;
    expectAt(c1 + EXP_READ - 1, SIG_READY, 1'b0, "R9 read window restarted");
    expectAt(c1 + EXP_READ,     SIG_READY, 1'b1, "R9 read window reached");
    waitTo(c1 + EXP_READ + 3);
    reqValid = 0;
    @(negedge clk);
    if (qCyc.size() != 0) begin
      mismatched += qCyc.size();
      $display("FAIL pending: actual %0d unchecked expected 0", qCyc.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cyc >= 20000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual cycle %0d expected finish", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule